// File: doc/BRIEF.md
# Dual Flash Topology Router

This block sits between a quad-SPI shifter that drives one serial flash device and a pair of identical external flash devices. A configuration word picks one of three arrangements. In single mode, only the lower device is connected. In stacked mode, both devices share the clock and the four I/O lines, and a page bit picks which device gets its select. In parallel mode, each device has its own four-bit bus and both are selected together.

In parallel mode the controller presents one byte per beat during the data phase. The bits at even positions in that byte go to the lower device and the bits at odd positions go to the upper one. A read rebuilds the byte in the same way from the two returned nibbles. Outside the data phase, the low nibble of the controller's word (command and address) is sent unchanged on both buses. The controller has only one chip select. The block derives the device selects from it. The configuration that steers a transfer is frozen while that select is active.

Every device-side output and the returned read word are registered. Each one shows the inputs sampled at the previous rising clock edge.

Top module: `dual_flash_router`

## Requirements
- R1: Single mode applies when configuration bit 30 is clear. Lower select (`dev_cs_n[0]`) follows `ctl_cs_n`. The upper select stays high, with upper clock and upper enable at 0. The lower clock follows `ctl_sck`.
- R2: Stacked mode applies when bit 30 is set and bit 29 is clear. During a transfer, bit 28 clear asserts only the lower select and bit 28 set asserts only the upper select. Both clocks follow `ctl_sck`.
- R3: Parallel mode applies when bits 30 and 29 are both set. Both selects follow `ctl_cs_n` and both clocks follow `ctl_sck`, regardless of bit 28.
- R4: Parallel-mode write in the data phase: lower bus bit i (`dev_dout[i]`) equals `ctl_wr[2i]`, and upper bus bit i (`dev_dout[4+i]`) equals `ctl_wr[2i+1]`.
- R5: Parallel-mode write outside the data phase: `ctl_wr[3:0]` goes unchanged to both buses.
- R6: Parallel-mode read in the data phase: `ctl_rd[2i]` = `dev_din[i]` (lower bus) and `ctl_rd[2i+1]` = `dev_din[4+i]` (upper bus).
- R7: Any other read: `ctl_rd[3:0]` takes the lower bus (`dev_din[3:0]`), except in stacked mode with bit 28 set, where it takes the upper bus (`dev_din[7:4]`). `ctl_rd[7:4]` is zero.
- R8: The mode and page bits are captured only at clock edges where `ctl_cs_n` is high. A change made while it is low has no effect until an edge where it is high again.
- R9: While `ctl_cs_n` is high, both device selects are high and both output enables are 0.
- R10: Reset is synchronous and active high. It drives both selects high and all clocks, enables, write data and read data to zero. It also clears the held configuration to single mode. Every output reflects the inputs of the previous edge.
- R11: A device's enable equals `ctl_oe` only while that device is selected. The write nibble of an unselected device is zero. All other configuration bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration word (bits 30, 29, 28 used) |
| ctl_cs_n | input | 1 | Controller chip select, active low |
| ctl_sck | input | 1 | Controller serial clock level |
| ctl_data_phase | input | 1 | High while the current beat carries payload data |
| ctl_oe | input | 1 | Controller wants to drive the I/O lines |
| ctl_wr | input | 8 | Write word: low nibble, or whole byte in parallel data phase |
| ctl_rd | output | 8 | Read word returned to the controller |
| dev_cs_n | output | 2 | Device selects, [0] lower, [1] upper, active low |
| dev_sck | output | 2 | Device clocks, [0] lower, [1] upper |
| dev_oe | output | 2 | I/O output enables per device |
| dev_dout | output | 8 | Device write data, [3:0] lower bus, [7:4] upper bus |
| dev_din | input | 8 | Device read data, [3:0] lower bus, [7:4] upper bus |

## Verification
The bench builds the block with its default parameters. These are a 32-bit configuration word with the mode and page bits at 30, 29 and 28, and four I/O lines per device, which gives an 8-bit interleaved word. With these defaults every bit of the even/odd split can be checked against a behavioural model, and configuration writes can be made to collide with an active select. Random traffic also sets the unused configuration bits and switches mode at the very edge where the select falls, which exercises the capture point of the held configuration.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_STACKED  = 2'd1,
    MODE_PARALLEL = 2'd2
  } route_mode_e;

  function automatic route_mode_e decode_mode(input logic dual_en, input logic sep_bus);
    if (!dual_en)    return MODE_SINGLE;
    else if (sep_bus) return MODE_PARALLEL;
    else             return MODE_STACKED;
  endfunction

endpackage

// File: rtl/dfr_cfg_hold.sv
module dfr_cfg_hold
  import dfr_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int DUAL_BIT = 30,
  parameter int SEP_BIT  = 29,
  parameter int PAGE_BIT = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_cs_n,
  input  logic [CFG_W-1:0]  cfg_word,
  output route_mode_e       mode_q,
  output logic              upper_q
);

  // Capture only while the controller is idle, so a transfer keeps its routing.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_SINGLE;
      upper_q <= 1'b0;
    end else if (ctl_cs_n) begin
      mode_q  <= decode_mode(cfg_word[DUAL_BIT], cfg_word[SEP_BIT]);
      upper_q <= cfg_word[PAGE_BIT];
    end
  end

endmodule

// File: rtl/dfr_tx_route.sv
module dfr_tx_route
  import dfr_pkg::*;
#(
  parameter int LANES = 4,
  localparam int WORD_W = 2 * LANES
) (
  input  route_mode_e        mode,
  input  logic               upper,
  input  logic               ctl_cs_n,
  input  logic               ctl_sck,
  input  logic               ctl_data_phase,
  input  logic               ctl_oe,
  input  logic [WORD_W-1:0]  ctl_wr,
  output logic [1:0]         cs_n_d,
  output logic [1:0]         sck_d,
  output logic [1:0]         oe_d,
  output logic [WORD_W-1:0]  dout_d
);

  logic [LANES-1:0] even_bits, odd_bits;
  logic [LANES-1:0] lo_word, up_word;
  logic             sel_lo, sel_up, split;

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign even_bits[i] = ctl_wr[2*i];
    assign odd_bits[i]  = ctl_wr[2*i+1];
  end

  assign split = (mode == MODE_PARALLEL) && ctl_data_phase;

  always_comb begin
    sel_lo = 1'b0;
    sel_up = 1'b0;
    sck_d  = 2'b00;
    unique case (mode)
      MODE_STACKED: begin
        sel_lo = !ctl_cs_n && !upper;
        sel_up = !ctl_cs_n && upper;
        sck_d  = {ctl_sck, ctl_sck};
      end
      MODE_PARALLEL: begin
        sel_lo = !ctl_cs_n;
        sel_up = !ctl_cs_n;
        sck_d  = {ctl_sck, ctl_sck};
      end
      default: begin
        sel_lo = !ctl_cs_n;
        sck_d  = {1'b0, ctl_sck};
      end
    endcase
  end

  assign lo_word = split ? even_bits : ctl_wr[LANES-1:0];
  assign up_word = split ? odd_bits  : ctl_wr[LANES-1:0];

  assign cs_n_d = {!sel_up, !sel_lo};
  assign oe_d   = {sel_up && ctl_oe, sel_lo && ctl_oe};
  assign dout_d = {sel_up ? up_word : '0, sel_lo ? lo_word : '0};

endmodule

// File: rtl/dfr_rx_merge.sv
module dfr_rx_merge
  import dfr_pkg::*;
#(
  parameter int LANES = 4,
  localparam int WORD_W = 2 * LANES
) (
  input  route_mode_e        mode,
  input  logic               upper,
  input  logic               ctl_data_phase,
  input  logic [WORD_W-1:0]  dev_din,
  output logic [WORD_W-1:0]  rd_d
);

  logic [WORD_W-1:0] woven;
  logic [LANES-1:0]  lo_bus, up_bus;

  assign lo_bus = dev_din[LANES-1:0];
  assign up_bus = dev_din[WORD_W-1:LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_weave
    assign woven[2*i]   = lo_bus[i];
    assign woven[2*i+1] = up_bus[i];
  end

  always_comb begin
    if (mode == MODE_PARALLEL && ctl_data_phase)
      rd_d = woven;
    else if (mode == MODE_STACKED && upper)
      rd_d = {{LANES{1'b0}}, up_bus};
    else
      rd_d = {{LANES{1'b0}}, lo_bus};
  end

endmodule

// File: rtl/dual_flash_router.sv
module dual_flash_router
  import dfr_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int DUAL_BIT = 30,
  parameter int SEP_BIT  = 29,
  parameter int PAGE_BIT = 28,
  parameter int LANES    = 4,
  localparam int WORD_W  = 2 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              ctl_cs_n,
  input  logic              ctl_sck,
  input  logic              ctl_data_phase,
  input  logic              ctl_oe,
  input  logic [WORD_W-1:0] ctl_wr,
  output logic [WORD_W-1:0] ctl_rd,
  output logic [1:0]        dev_cs_n,
  output logic [1:0]        dev_sck,
  output logic [1:0]        dev_oe,
  output logic [WORD_W-1:0] dev_dout,
  input  logic [WORD_W-1:0] dev_din
);

  route_mode_e       mode_q;
  logic              upper_q;
  logic [1:0]        cs_n_d, sck_d, oe_d;
  logic [WORD_W-1:0] dout_d, rd_d;

  dfr_cfg_hold #(
    .CFG_W(CFG_W), .DUAL_BIT(DUAL_BIT), .SEP_BIT(SEP_BIT), .PAGE_BIT(PAGE_BIT)
  ) u_cfg (
    .clk(clk), .rst(rst), .ctl_cs_n(ctl_cs_n), .cfg_word(cfg_word),
    .mode_q(mode_q), .upper_q(upper_q)
  );

  dfr_tx_route #(.LANES(LANES)) u_tx (
    .mode(mode_q), .upper(upper_q), .ctl_cs_n(ctl_cs_n), .ctl_sck(ctl_sck),
    .ctl_data_phase(ctl_data_phase), .ctl_oe(ctl_oe), .ctl_wr(ctl_wr),
    .cs_n_d(cs_n_d), .sck_d(sck_d), .oe_d(oe_d), .dout_d(dout_d)
  );

  dfr_rx_merge #(.LANES(LANES)) u_rx (
    .mode(mode_q), .upper(upper_q), .ctl_data_phase(ctl_data_phase),
    .dev_din(dev_din), .rd_d(rd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_cs_n <= 2'b11;
      dev_sck  <= 2'b00;
      dev_oe   <= 2'b00;
      dev_dout <= '0;
      ctl_rd   <= '0;
    end else begin
      dev_cs_n <= cs_n_d;
      dev_sck  <= sck_d;
      dev_oe   <= oe_d;
      dev_dout <= dout_d;
      ctl_rd   <= rd_d;
    end
  end

endmodule

// File: rtl/dfr_checker.sv
module dfr_checker
  import dfr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        ctl_cs_n,
  input route_mode_e mode_q,
  input logic        upper_q,
  input logic [1:0]  dev_cs_n,
  input logic [1:0]  dev_sck,
  input logic [1:0]  dev_oe
);

  logic ok_q;
  always_ff @(posedge clk) begin
    if (rst) ok_q <= 1'b0;
    else     ok_q <= 1'b1;
  end

  a_r1_single_upper_off: assert property (@(posedge clk) disable iff (rst)
    ok_q && $past(mode_q) == MODE_SINGLE |-> dev_cs_n[1] && !dev_oe[1] && !dev_sck[1]);

  a_r2_stacked_one_select: assert property (@(posedge clk) disable iff (rst)
    ok_q && $past(mode_q) == MODE_STACKED |-> $onehot0(~dev_cs_n));

  a_r2_stacked_page: assert property (@(posedge clk) disable iff (rst)
    ok_q && $past(mode_q) == MODE_STACKED && !$past(ctl_cs_n)
      |-> dev_cs_n == ($past(upper_q) ? 2'b01 : 2'b10));

  a_r3_both_only_parallel: assert property (@(posedge clk) disable iff (rst)
    ok_q && dev_cs_n == 2'b00 |-> $past(mode_q) == MODE_PARALLEL);

  a_r8_cfg_held: assert property (@(posedge clk) disable iff (rst)
    ok_q && !$past(ctl_cs_n) |-> $stable(mode_q) && $stable(upper_q));

  a_r9_idle_deselect: assert property (@(posedge clk) disable iff (rst)
    ok_q && $past(ctl_cs_n) |-> dev_cs_n == 2'b11 && dev_oe == 2'b00);

endmodule

bind dual_flash_router dfr_checker u_chk (
  .clk(clk), .rst(rst), .ctl_cs_n(ctl_cs_n), .mode_q(mode_q), .upper_q(upper_q),
  .dev_cs_n(dev_cs_n), .dev_sck(dev_sck), .dev_oe(dev_oe)
);

// File: tb/tb_dual_flash_router.sv
module tb_dual_flash_router;
  localparam int LN = 4;
  localparam int WW = 2 * LN;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   cfg_word = '0;
  logic          ctl_cs_n = 1'b1, ctl_sck = 1'b0, ctl_data_phase = 1'b0, ctl_oe = 1'b0;
  logic [WW-1:0] ctl_wr = '0, dev_din = '0;
  logic [WW-1:0] ctl_rd, dev_dout;
  logic [1:0]    dev_cs_n, dev_sck, dev_oe;

  dual_flash_router dut (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .ctl_cs_n(ctl_cs_n), .ctl_sck(ctl_sck),
    .ctl_data_phase(ctl_data_phase), .ctl_oe(ctl_oe), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .dev_cs_n(dev_cs_n), .dev_sck(dev_sck), .dev_oe(dev_oe), .dev_dout(dev_dout),
    .dev_din(dev_din)
  );

  always #10 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0, mvalid = 1'b0;
  bit    m_dual = 0, m_sep = 0, m_up = 0;
  logic [1:0]    e_cs, e_sck, e_oe;
  logic [WW-1:0] e_dout, e_rd;
  string t_sel, t_dat, t_rd;

  // Behavioural reference, one registered stage
  always @(posedge clk) begin : model
    bit act, s_lo, s_up, split, cfg_moved;
    logic [LN-1:0] lo, up;
    mvalid <= 1'b1;
    if (rst) begin
      e_cs <= 2'b11; e_sck <= 2'b00; e_oe <= 2'b00; e_dout <= '0; e_rd <= '0;
      t_sel <= "R10"; t_dat <= "R10"; t_rd <= "R10";
      m_dual = 0; m_sep = 0; m_up = 0;
    end else begin
      act = !ctl_cs_n;
      cfg_moved = act && ({cfg_word[30], cfg_word[29], cfg_word[28]} != {m_dual, m_sep, m_up});
      if (!m_dual)     begin s_lo = act; s_up = 0; end
      else if (m_sep)  begin s_lo = act; s_up = act; end
      else             begin s_lo = act && !m_up; s_up = act && m_up; end
      e_cs  <= {!s_up, !s_lo};
      e_sck <= m_dual ? {ctl_sck, ctl_sck} : {1'b0, ctl_sck};
      e_oe  <= {s_up && ctl_oe, s_lo && ctl_oe};
      split = m_dual && m_sep && ctl_data_phase;
      for (int i = 0; i < LN; i++) begin
        lo[i] = split ? ctl_wr[2*i]   : ctl_wr[i];
        up[i] = split ? ctl_wr[2*i+1] : ctl_wr[i];
      end
      e_dout <= {s_up ? up : 4'h0, s_lo ? lo : 4'h0};
      if (split) begin
        logic [WW-1:0] w;
        for (int i = 0; i < LN; i++) begin
          w[2*i] = dev_din[i]; w[2*i+1] = dev_din[LN+i];
        end
        e_rd <= w;
      end else if (m_dual && !m_sep && m_up) e_rd <= {4'h0, dev_din[7:4]};
      else                                   e_rd <= {4'h0, dev_din[3:0]};
      t_sel <= !act ? "R9" : cfg_moved ? "R8" : !m_dual ? "R1" : m_sep ? "R3" : "R2";
      t_dat <= split ? "R4" : (m_dual && m_sep) ? "R5" : "R11";
      t_rd  <= split ? "R6" : "R7";
      if (ctl_cs_n) begin m_dual = cfg_word[30]; m_sep = cfg_word[29]; m_up = cfg_word[28]; end
    end
  end

  task automatic chk(string tag, string what, logic [WW-1:0] act_v, logic [WW-1:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (mvalid && !done) begin
    chk(t_sel, "dev_cs_n", {6'b0, dev_cs_n}, {6'b0, e_cs});
    chk(t_sel, "dev_sck",  {6'b0, dev_sck},  {6'b0, e_sck});
    chk(t_sel, "dev_oe",   {6'b0, dev_oe},   {6'b0, e_oe});
    chk(t_dat, "dev_dout", dev_dout, e_dout);
    chk(t_rd,  "ctl_rd",   ctl_rd,   e_rd);
  end

  task automatic beat(bit cs_n, bit dp, bit oe, logic [7:0] wr, logic [7:0] din);
    @(negedge clk);
    ctl_cs_n = cs_n; ctl_sck = ~ctl_sck; ctl_data_phase = dp; ctl_oe = oe;
    ctl_wr = wr; dev_din = din;
  endtask

  // One transfer: idle with new cfg, 3 command beats, 3 data beats, idle
  task automatic xfer(logic [31:0] cfg, logic [31:0] mid_cfg);
    @(negedge clk); cfg_word = cfg;
    beat(1, 0, 0, 8'h00, 8'h00);
    beat(0, 0, 1, 8'hA5, 8'h3C);
    beat(0, 0, 1, 8'h5A, 8'hC3);
    cfg_word = mid_cfg;                               // R8: change during transfer
    beat(0, 0, 1, 8'hF0, 8'h96);
    beat(0, 1, 1, 8'hAA, 8'hF0);                      // R4/R6 alternating patterns
    beat(0, 1, 1, 8'h55, 8'h0F);
    beat(0, 1, 0, 8'h81, 8'h5A);
    beat(1, 0, 0, 8'hFF, 8'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;                       // R10 checked during reset above
    xfer(32'h0000_0000, 32'h6000_0000);               // R1 single, R8 switch to parallel
    xfer(32'h4000_0000, 32'h5000_0000);               // R2 stacked lower
    xfer(32'h5000_0000, 32'h4000_0000);               // R2 stacked upper
    xfer(32'h6000_0000, 32'h0000_0000);               // R3 R4 R5 R6 parallel
    xfer(32'h7000_0000, 32'h5000_0000);               // R3 page bit ignored
    xfer(32'h8FFF_FFFF, 32'h4000_0000);               // R11 other bits ignored
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom_range(7) == 0) ctl_cs_n = ~ctl_cs_n;
      if ($urandom_range(5) == 0) cfg_word = $urandom;
      ctl_sck = $urandom; ctl_data_phase = $urandom; ctl_oe = $urandom;
      ctl_wr = $urandom; dev_din = $urandom;
    end
    @(negedge clk); rst = 1'b1;                       // R10 mid-run reset
    @(negedge clk); @(negedge clk); rst = 1'b0;
    beat(1, 0, 0, 8'h00, 8'h00);
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule